// File: doc/BRIEF.md
# Smart card character transceiver

This block moves single characters over the one-wire, half-duplex data line of an ISO 7816 style IC card. Each character on the line is one start bit, eight data bits and a parity bit, followed by two guard bits. During the guard bits the receiving side may pull the line low to reject the character. The line is open-drain. The block reads the line on `io_in` and pulls it low while `io_oe` is high.

Three independent controls select the card convention. They set the bit order (LSB or MSB first), the inversion of the data and parity bits, and the parity sense (even or odd). The block also produces the card clock. In normal mode the clock is either running or held low. In GSM mode the clock is either running or parked at a chosen level.

Software-facing signals are kept minimal:
- a transmit byte with a write strobe,
- a receive byte with a read strobe,
- six status flags,
- one strobe that clears the error and completion flags.

One bit time lasts `(cfg_rate+1) * 4^cfg_prescale` clock cycles.

Top module: `sc_char_unit`

## Requirements
- R1: After reset, `tx_empty` is 1. `rx_full`, `overrun`, `parity_err`, `err_sig`, `tx_end`, `io_oe` and `card_clk` are all 0.
- R2: A transmitted character is sent as follows. The start bit comes first, then the eight data bits, then parity. Each bit lasts P = (cfg_rate+1)*4^cfg_prescale clocks. Data goes bit 0 first when `cfg_msb_first`=0 and bit 7 first when it is 1.
- R3: The start bit is always driven low. When `cfg_invert`=1, every data bit and the parity bit appear complemented on the line.
- R4: The parity value, before any inversion, is the XOR of the eight data bits when `cfg_odd_parity`=0, and its complement when it is 1.
- R5: After the parity bit, the transmitter releases the line for two bit times. If the line is low at the middle of the first of these, `err_sig` is set; otherwise `tx_end` is set. `tx_empty` returns to 1 on the last cycle of the second guard bit, exactly 12·P clocks after the start bit began.
- R6: A `tx_wr` strobe while `tx_empty`=0 is ignored: the character in flight is unchanged, and no further character follows it.
- R7: A low line while idle starts reception. Each bit is sampled at mid-bit, using the same order and inversion as transmit. A good character lands in `rx_data` with `rx_full`=1, one clock after its parity bit ends. `rx_rd` clears `rx_full`.
- R8: On a parity mismatch, `parity_err` is set and the byte is discarded. The block also holds `io_oe` high for the whole first guard bit (P clocks).
- R9: A good character that completes while `rx_full`=1 sets `overrun` and leaves `rx_data` unchanged.
- R10: Card clock behaviour depends on `cfg_clk_en` and `cfg_gsm`:
  - With `cfg_clk_en[0]`=1, `card_clk` toggles every clock.
  - With `cfg_clk_en[0]`=0 and `cfg_gsm`=0, it is low whatever `cfg_clk_en[1]` is.
  - With `cfg_clk_en[0]`=0 and `cfg_gsm`=1, it is held at the level of `cfg_clk_en[1]`.
- R11: `err_clr` clears `overrun`, `parity_err`, `err_sig` and `tx_end`. A successful `tx_wr` also clears `tx_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_msb_first | input | 1 | 1: bit 7 first on the line |
| cfg_invert | input | 1 | 1: data and parity bits complemented on the line |
| cfg_odd_parity | input | 1 | 1: odd parity, 0: even parity |
| cfg_gsm | input | 1 | Card clock mode: 1 allows a parked high level |
| cfg_clk_en | input | 2 | Card clock enable (bit 0) and park level (bit 1) |
| cfg_prescale | input | 2 | Bit-period prescale, factor 4^value |
| cfg_rate | input | 8 | Bit-period divider minus one |
| tx_wr | input | 1 | Load `tx_data` when `tx_empty` is 1 |
| tx_data | input | 8 | Byte to send |
| rx_rd | input | 1 | Acknowledge received byte |
| err_clr | input | 1 | Clear error and completion flags |
| io_in | input | 1 | Data line level |
| io_oe | output | 1 | Pull the data line low |
| card_clk | output | 1 | Clock to the card |
| rx_data | output | 8 | Last good received byte |
| tx_empty | output | 1 | Transmit holding byte free |
| tx_end | output | 1 | Last character accepted by the card |
| rx_full | output | 1 | `rx_data` holds an unread byte |
| overrun | output | 1 | A byte was lost to an unread one |
| parity_err | output | 1 | A received character failed parity |
| err_sig | output | 1 | The card rejected a sent character |

## Verification
The hardest cases to reach from the ports both involve the guard period, where the two ends of the line swap roles.

In the first case, the card pulls the line low after the parity bit of a sent character. In the second, the block itself pulls the line low after a received character with bad parity.

The bench models the line as a wired AND of `io_oe` and a card-side pull, and plays the card bit by bit. This lets it inject a low guard bit at a known clock and deliberately flip a parity bit. It then checks the flags and the exact window of the block's own pull. Overrun is reached by sending two good characters back to back without a read.

// File: rtl/sc_char_unit.sv
module sc_char_unit #(
  parameter int RATE_W = 8,
  parameter int PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic              cfg_odd_parity,
  input  logic              cfg_gsm,
  input  logic [1:0]        cfg_clk_en,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              tx_wr,
  input  logic [7:0]        tx_data,
  input  logic              rx_rd,
  input  logic              err_clr,
  input  logic              io_in,
  output logic              io_oe,
  output logic              card_clk,
  output logic [7:0]        rx_data,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              rx_full,
  output logic              overrun,
  output logic              parity_err,
  output logic              err_sig
);
  localparam int CNT_W = RATE_W + 2 * ((1 << PRE_W) - 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt, period;
  logic [3:0] bitn;
  logic [7:0] tx_hold, sh;
  logic perr, tx_err, bit_end, mid, tx_line, rbit;
  logic [2:0] bidx, pos;

  assign period  = (CNT_W'(cfg_rate) + CNT_W'(1)) << {cfg_prescale, 1'b0};
  assign bit_end = cnt == period - CNT_W'(1);
  assign mid     = cnt == (period >> 1);
  assign bidx    = bitn[2:0] - 3'd1;
  assign pos     = cfg_msb_first ? ~bidx : bidx;
  assign rbit    = io_in ^ cfg_invert;

  always_comb begin
    if (bitn == 4'd0)      tx_line = 1'b0;
    else if (bitn <= 4'd8) tx_line = tx_hold[pos] ^ cfg_invert;
    else if (bitn == 4'd9) tx_line = ^tx_hold ^ cfg_odd_parity ^ cfg_invert;
    else                   tx_line = 1'b1;
  end

  assign io_oe = (st == S_TX && !tx_line) || (st == S_RX && bitn == 4'd10 && perr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) card_clk <= 1'b0;
    else        card_clk <= cfg_clk_en[0] ? ~card_clk : (cfg_gsm & cfg_clk_en[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bitn <= '0;
      tx_hold <= '0;
      sh <= '0;
      perr <= 1'b0;
      tx_err <= 1'b0;
      rx_data <= '0;
      tx_empty <= 1'b1;
      tx_end <= 1'b0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
      parity_err <= 1'b0;
      err_sig <= 1'b0;
    end else begin
      if (rx_rd) rx_full <= 1'b0;
      if (err_clr) begin
        overrun <= 1'b0;
        parity_err <= 1'b0;
        err_sig <= 1'b0;
        tx_end <= 1'b0;
      end
      if (tx_wr && tx_empty) begin
        tx_hold <= tx_data;
        tx_empty <= 1'b0;
        tx_end <= 1'b0;
      end
      if (st == S_IDLE) begin
        cnt <= '0;
        bitn <= '0;
        perr <= 1'b0;
        tx_err <= 1'b0;
        if (!tx_empty)  st <= S_TX;
        else if (!io_in) st <= S_RX;
      end else begin
        if (bit_end) begin
          cnt <= '0;
          bitn <= bitn + 4'd1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        if (bitn == 4'd11 && bit_end) st <= S_IDLE;
        if (st == S_TX) begin
          if (bitn == 4'd10 && mid && !io_in) tx_err <= 1'b1;
          if (bitn == 4'd11 && bit_end) begin
            tx_empty <= 1'b1;
            if (tx_err) err_sig <= 1'b1;
            else        tx_end <= 1'b1;
          end
        end else begin
          if (bitn == 4'd0 && mid && io_in) st <= S_IDLE;
          if (mid && bitn >= 4'd1 && bitn <= 4'd8)
            sh <= cfg_msb_first ? {sh[6:0], rbit} : {rbit, sh[7:1]};
          if (mid && bitn == 4'd9) perr <= rbit != (^sh ^ cfg_odd_parity);
          if (bitn == 4'd9 && bit_end) begin
            if (perr) parity_err <= 1'b1;
            else if (rx_full && !rx_rd) overrun <= 1'b1;
            else begin
              rx_data <= sh;
              rx_full <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rx_rd |=> rx_full && $stable(rx_data));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !io_oe);
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TX && bitn == 4'd0 |-> io_oe);
  assert_busy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && !tx_empty |=> $stable(tx_hold));
  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> tx_end || err_sig);
  assert_clk_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_en[0] |=> card_clk != $past(card_clk));
  assert_clk_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk_en[0] && !cfg_gsm |=> !card_clk);
endmodule

// File: tb/test_sc_char_unit.sv
module test_sc_char_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_msb_first = 0, cfg_invert = 0, cfg_odd_parity = 0, cfg_gsm = 0;
  logic [1:0] cfg_clk_en = 2'b00, cfg_prescale = 2'd0;
  logic [7:0] cfg_rate = 8'd7, tx_data = 8'h00;
  logic tx_wr = 0, rx_rd = 0, err_clr = 0, card_low = 0;
  logic io_in, io_oe, card_clk, tx_empty, tx_end, rx_full, overrun, parity_err, err_sig;
  logic [7:0] rx_data;

  int checks = 0, errors = 0, P = 8;
  logic exp_ck = 1'b0, cmp_on = 1'b0;
  logic m_full = 0, m_ovr = 0, m_perr = 0, m_esig = 0, m_tend = 0;
  logic [7:0] m_data = 8'h00;

  assign io_in = !io_oe && !card_low;

  sc_char_unit i_sc_char_unit (
    .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
    .cfg_odd_parity(cfg_odd_parity), .cfg_gsm(cfg_gsm), .cfg_clk_en(cfg_clk_en),
    .cfg_prescale(cfg_prescale), .cfg_rate(cfg_rate), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .err_clr(err_clr), .io_in(io_in), .io_oe(io_oe), .card_clk(card_clk),
    .rx_data(rx_data), .tx_empty(tx_empty), .tx_end(tx_end), .rx_full(rx_full),
    .overrun(overrun), .parity_err(parity_err), .err_sig(err_sig));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk)
    if (!rst_n) exp_ck <= 1'b0;
    else exp_ck <= cfg_clk_en[0] ? ~exp_ck : (cfg_gsm & cfg_clk_en[1]);

  always @(negedge clk)
    if (rst_n && cmp_on) chk("R10 card clock per cycle", card_clk, exp_ck);

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [9:0] frame_lv(input logic [7:0] d, input logic flip);
    logic [9:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = (cfg_msb_first ? d[7-i] : d[i]) ^ cfg_invert;
    f[9] = (^d) ^ cfg_odd_parity ^ cfg_invert ^ flip;
    return f;
  endfunction

  task automatic flags_chk(input string req);
    chk({req, " rx_full"}, rx_full, m_full);
    if (m_full) chk({req, " rx_data"}, rx_data, m_data);
    chk({req, " parity_err"}, parity_err, m_perr);
    chk({req, " overrun"}, overrun, m_ovr);
    chk({req, " err_sig"}, err_sig, m_esig);
    chk({req, " tx_end"}, tx_end, m_tend);
  endtask

  task automatic send(input logic [7:0] d, input logic inject, input logic busy_wr);
    logic [9:0] f;
    int t;
    f = frame_lv(d, 1'b0);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    m_tend = 1'b0;
    t = 0;
    while (!io_oe && t < 20) begin @(negedge clk); t++; end
    chk("R2 start seen", io_oe, 1);
    repeat (P / 2) @(negedge clk);
    chk("R3 start bit low", !io_oe, 0);
    for (int i = 1; i < 10; i++) begin
      repeat (P) begin @(negedge clk); tx_wr = 1'b0; end
      chk(i == 9 ? "R4 parity bit" : "R2 data bit", !io_oe, f[i]);
      if (busy_wr && i == 3) begin tx_wr = 1'b1; tx_data = ~d; end
    end
    repeat (P / 2) @(negedge clk);
    if (inject) card_low = 1'b1;
    repeat (P) @(negedge clk);
    card_low = 1'b0;
    repeat (P - 1) @(negedge clk);
    chk("R5 tx_empty before end", tx_empty, 0);
    @(negedge clk);
    chk("R5 tx_empty at end", tx_empty, 1);
    if (inject) m_esig = 1'b1; else m_tend = 1'b1;
    flags_chk("R5");
  endtask

  task automatic recv(input logic [7:0] d, input logic bad);
    logic [9:0] f;
    f = frame_lv(d, bad);
    for (int i = 0; i < 10; i++) begin
      card_low = !f[i];
      repeat (P) @(negedge clk);
    end
    card_low = 1'b0;
    @(negedge clk);
    if (bad) m_perr = 1'b1;
    else if (m_full) m_ovr = 1'b1;
    else begin m_full = 1'b1; m_data = d; end
    flags_chk(bad ? "R8" : (m_ovr ? "R9" : "R7"));
    chk("R8 guard drive start", io_oe, bad);
    repeat (P - 1) @(negedge clk);
    chk("R8 guard drive last", io_oe, bad);
    @(negedge clk);
    chk("R8 guard drive released", io_oe, 0);
    repeat (P + 2) @(negedge clk);
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    m_full = 1'b0;
    chk("R7 rx_rd clears rx_full", rx_full, 0);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_ovr = 0; m_perr = 0; m_esig = 0; m_tend = 0;
    flags_chk("R11 err_clr");
  endtask

  task automatic clk_mode(input logic gsm, input logic [1:0] en, input int lvl);
    @(negedge clk); cfg_gsm = gsm; cfg_clk_en = en;
    repeat (3) @(negedge clk);
    chk("R10 parked level", card_clk, lvl);
  endtask

  initial begin
    int bad_drive;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 io_oe", io_oe, 0);
    chk("R1 card_clk", card_clk, 0);
    flags_chk("R1");
    cmp_on = 1'b1;
    cfg_clk_en = 2'b01;
    repeat (4) @(negedge clk);

    send(8'hA5, 1'b0, 1'b0);
    send(8'h3C, 1'b0, 1'b0);
    send(8'h5A, 1'b1, 1'b0);
    clear_err();
    send(8'h81, 1'b0, 1'b1);
    bad_drive = 0;
    repeat (4 * P) begin @(negedge clk); if (io_oe) bad_drive = 1; end
    chk("R6 no second character", bad_drive, 0);
    chk("R6 tx_empty stays", tx_empty, 1);

    cfg_msb_first = 1; cfg_invert = 1; cfg_odd_parity = 1;
    cfg_prescale = 2'd1; cfg_rate = 8'd1; P = 8;
    send(8'h3B, 1'b0, 1'b0);
    send(8'hC4, 1'b0, 1'b0);
    recv(8'h3B, 1'b0);
    read_rx();

    cfg_msb_first = 0; cfg_invert = 0; cfg_odd_parity = 0;
    cfg_prescale = 2'd0; cfg_rate = 8'd7;
    repeat (2) @(negedge clk);
    recv(8'h96, 1'b0);
    recv(8'h47, 1'b0);
    read_rx();
    recv(8'h47, 1'b1);
    chk("R8 byte not stored", rx_full, 0);
    clear_err();
    recv(8'h6E, 1'b0);
    read_rx();

    clk_mode(1'b0, 2'b00, 0);
    clk_mode(1'b0, 2'b10, 0);
    clk_mode(1'b1, 2'b10, 1);
    clk_mode(1'b1, 2'b00, 0);
    @(negedge clk); cfg_clk_en = 2'b11;
    repeat (6) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule